// File: doc/BRIEF.md
# ACK duration table generator

This block fills a small lookup table with acknowledgement air times, one entry for each of twelve transmit rate indices. Indices 0 to 3 are CCK rates (1, 2, 5.5 and 11 Mb/s). Indices 4 to 11 are OFDM rates (6, 9, 12, 18, 24, 36, 48 and 54 Mb/s). A start pulse makes the block walk the rate indices in ascending order. For each index it chooses the rate at which the acknowledgement will be sent. It hands that rate to an internal duration calculator through a valid/ready handshake. It then writes the returned microsecond value into the table.

A mode input selects how the acknowledgement rate is chosen. With the mode off, each family falls back to its base rate. With the mode on, a fixed mapping picks a faster rate that still sits at or below the transmit rate. The three CCK rates that allow a short preamble get the same value written a second time, into a slot in the upper half of the table. A combinational read port lets the rest of the chip look up any slot at any time.

Top module: `ack_dur_table_gen`

## Requirements
- R1: After reset `busy` and `done` are 0, and every slot of the table reads 0.
- R2: A `start` pulse while idle makes `busy` read 1 one clock later. A `start` pulse while `busy` is 1 is ignored: it produces no second `done` and no second walk.
- R3: With the mode off (`ack_hi_en`=0 at start), slots 0 to 3 hold the duration at rate index 0 (1 Mb/s), and slots 4 to 11 hold the duration at rate index 4 (6 Mb/s).
- R4: With the mode on, rate indices 0 to 11 use acknowledgement rate indices 0,1,1,1,4,4,6,6,8,8,8,8 respectively.
- R5: A CCK acknowledgement duration equals 10 + 192 + ceil(80*10 / r) µs, where r is the rate in 100 kb/s units (10, 20, 55, 110). For example, 1 Mb/s gives 282 and 2 Mb/s gives 242.
- R6: An OFDM acknowledgement duration equals 16 + 20 + 4*ceil((22+80)*10 / (4*r)) µs, where r is 60, 90, 120, 180, 240, 360, 480 or 540. For example, 6 Mb/s gives 56, 12 Mb/s gives 48 and 24 Mb/s gives 44.
- R7: Slots 13, 14 and 15 (12 plus rate index 1, 2 or 3) hold the same value as slots 1, 2 and 3. Slots 12 and 16 to 23 stay 0.
- R8: `done` is high for exactly one cycle after the last slot is written, and `busy` is 0 in that cycle.
- R9: Read addresses 24 to 31 return 0.
- R10: `ack_hi_en` is sampled at start. Changing it during a walk has no effect on that walk.
- R11: A later walk overwrites every written slot, so the table reflects the mode of the most recent walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a table walk (single-cycle pulse) |
| ack_hi_en | input | 1 | Selects the faster acknowledgement rate mapping |
| busy | output | 1 | High while a walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| rd_addr | input | 5 | Table slot to read |
| rd_data | output | 16 | Duration stored at `rd_addr`, in µs |

## Verification
A new start request and an in-progress walk can land in the same cycle. The same is true of a mode change and the mode latched for the walk. The bench provokes both by pulsing `start` and flipping `ack_hi_en` partway through a walk. It then judges the outcome in three ways. It counts `done` pulses over a long window afterwards. It compares every slot against values computed arithmetically for the mode held at the first start. A second walk in the other mode must then replace those values.

// File: rtl/ackdur_pkg.sv
package ackdur_pkg;

    localparam int NRATES   = 12;
    localparam int NCCK     = 4;
    localparam int RIDX_W   = $clog2(NRATES);
    localparam int NSLOTS   = 2 * NRATES;
    localparam int SLOT_W   = $clog2(NSLOTS);

    localparam int CCK_SIFS_US   = 10;
    localparam int CCK_PRE_US    = 192;
    localparam int OFDM_SIFS_US  = 16;
    localparam int OFDM_PRE_US   = 20;
    localparam int OFDM_SYM_US   = 4;
    localparam int OFDM_HDR_BITS = 22;

    typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT, SQ_DUP} seq_e;
    typedef enum logic [1:0] {CL_IDLE, CL_RUN, CL_HOLD} calc_e;

    function automatic int rate_100k(input logic [RIDX_W-1:0] idx);
        case (idx)
            4'd0:    rate_100k = 10;
            4'd1:    rate_100k = 20;
            4'd2:    rate_100k = 55;
            4'd3:    rate_100k = 110;
            4'd4:    rate_100k = 60;
            4'd5:    rate_100k = 90;
            4'd6:    rate_100k = 120;
            4'd7:    rate_100k = 180;
            4'd8:    rate_100k = 240;
            4'd9:    rate_100k = 360;
            4'd10:   rate_100k = 480;
            default: rate_100k = 540;
        endcase
    endfunction

endpackage

// File: rtl/ackdur_rate_map.sv
module ackdur_rate_map
    import ackdur_pkg::*;
(
    input  logic [RIDX_W-1:0] tx_idx,
    input  logic              hi_mode,
    output logic [RIDX_W-1:0] ack_idx,
    output logic              dual_slot
);

    always_comb begin
        if (!hi_mode) begin
            ack_idx = (int'(tx_idx) < NCCK) ? RIDX_W'(0) : RIDX_W'(NCCK);
        end else begin
            case (tx_idx)
                4'd0:       ack_idx = 4'd0;
                4'd1, 4'd2,
                4'd3:       ack_idx = 4'd1;
                4'd4, 4'd5: ack_idx = 4'd4;
                4'd6, 4'd7: ack_idx = 4'd6;
                default:    ack_idx = 4'd8;
            endcase
        end
        dual_slot = (tx_idx != '0) && (int'(tx_idx) < NCCK);
    end

endmodule

// File: rtl/ackdur_calc.sv
module ackdur_calc
    import ackdur_pkg::*;
#(
    parameter int DUR_W     = 16,
    parameter int ACK_BYTES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [RIDX_W-1:0] in_rate,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DUR_W-1:0]  out_dur
);

    localparam int NUM_MAX = (OFDM_HDR_BITS + 8 * ACK_BYTES) * 10;
    localparam int NUM_W   = $clog2(NUM_MAX + 1);
    localparam int DIV_W   = 12;
    localparam int REM_W   = ((NUM_W > DIV_W) ? NUM_W : DIV_W) + 2;
    localparam int Q_W     = NUM_W;

    typedef struct packed {
        calc_e                    st;
        logic signed [REM_W-1:0]  rem;
        logic [DIV_W-1:0]         div;
        logic [Q_W-1:0]           quo;
        logic                     cck;
        logic [DUR_W-1:0]         dur;
    } calc_s;

    calc_s c_q, c_d;

    always_comb begin
        c_d = c_q;
        case (c_q.st)
            CL_IDLE: begin
                if (in_valid) begin
                    c_d.cck = int'(in_rate) < NCCK;
                    c_d.rem = c_d.cck ? REM_W'(8 * ACK_BYTES * 10)
                                      : REM_W'(NUM_MAX);
                    c_d.div = c_d.cck ? DIV_W'(rate_100k(in_rate))
                                      : DIV_W'(rate_100k(in_rate) * OFDM_SYM_US);
                    c_d.quo = '0;
                    c_d.st  = CL_RUN;
                end
            end
            CL_RUN: begin
                if (c_q.rem > 0) begin
                    c_d.rem = c_q.rem - REM_W'($signed({1'b0, c_q.div}));
                    c_d.quo = c_q.quo + Q_W'(1);
                end else begin
                    c_d.dur = c_q.cck
                        ? DUR_W'(CCK_SIFS_US + CCK_PRE_US) + DUR_W'(c_q.quo)
                        : DUR_W'(OFDM_SIFS_US + OFDM_PRE_US)
                          + DUR_W'(c_q.quo) * DUR_W'(OFDM_SYM_US);
                    c_d.st  = CL_HOLD;
                end
            end
            CL_HOLD: begin
                if (out_ready) c_d.st = CL_IDLE;
            end
            default: c_d.st = CL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: CL_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign in_ready  = (c_q.st == CL_IDLE);
    assign out_valid = (c_q.st == CL_HOLD);
    assign out_dur   = c_q.dur;

    // R6: a presented result stays put until it is taken
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_dur)));

    // R5: the divider never runs with a zero divisor
    p_div_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == CL_RUN) |-> (c_q.div != '0));

endmodule

// File: rtl/ackdur_table.sv
module ackdur_table #(
    parameter int DEPTH = 24,
    parameter int DW    = 16,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DW-1:0] slot_d;
        always_comb begin
            slot_d = slot_q[g];
            if (we && (int'(waddr) == g)) slot_d = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(raddr) < DEPTH) rdata = slot_q[raddr];
    end

    // R7: every write lands inside the table
    p_wr_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < DEPTH));

endmodule

// File: rtl/ack_dur_table_gen.sv
module ack_dur_table_gen
    import ackdur_pkg::*;
#(
    parameter int DUR_W     = 16,
    parameter int ACK_BYTES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ack_hi_en,
    output logic              busy,
    output logic              done,
    input  logic [SLOT_W-1:0] rd_addr,
    output logic [DUR_W-1:0]  rd_data
);

    localparam logic [RIDX_W-1:0] LAST_IDX = RIDX_W'(NRATES - 1);

    typedef struct packed {
        seq_e              st;
        logic [RIDX_W-1:0] idx;
        logic              hi;
        logic              done;
        logic [DUR_W-1:0]  dur;
    } seq_s;

    seq_s s_q, s_d;

    logic [RIDX_W-1:0] ack_idx;
    logic              dual_slot;
    logic              calc_in_valid, calc_in_ready;
    logic              calc_out_valid, calc_out_ready;
    logic [DUR_W-1:0]  calc_dur;
    logic              tbl_we;
    logic [SLOT_W-1:0] tbl_waddr;
    logic [DUR_W-1:0]  tbl_wdata;

    ackdur_rate_map i_map (
        .tx_idx    (s_q.idx),
        .hi_mode   (s_q.hi),
        .ack_idx   (ack_idx),
        .dual_slot (dual_slot)
    );

    ackdur_calc #(.DUR_W(DUR_W), .ACK_BYTES(ACK_BYTES)) i_calc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (calc_in_valid),
        .in_ready  (calc_in_ready),
        .in_rate   (ack_idx),
        .out_valid (calc_out_valid),
        .out_ready (calc_out_ready),
        .out_dur   (calc_dur)
    );

    ackdur_table #(.DEPTH(NSLOTS), .DW(DUR_W), .AW(SLOT_W)) i_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_waddr),
        .wdata (tbl_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    always_comb begin
        s_d            = s_q;
        s_d.done       = 1'b0;
        calc_in_valid  = 1'b0;
        calc_out_ready = 1'b0;
        tbl_we         = 1'b0;
        tbl_waddr      = SLOT_W'(s_q.idx);
        tbl_wdata      = calc_dur;
        case (s_q.st)
            SQ_IDLE: begin
                if (start) begin
                    s_d.st  = SQ_REQ;
                    s_d.idx = '0;
                    s_d.hi  = ack_hi_en;
                end
            end
            SQ_REQ: begin
                calc_in_valid = 1'b1;
                if (calc_in_ready) s_d.st = SQ_WAIT;
            end
            SQ_WAIT: begin
                calc_out_ready = 1'b1;
                if (calc_out_valid) begin
                    tbl_we  = 1'b1;
                    s_d.dur = calc_dur;
                    if (dual_slot) begin
                        s_d.st = SQ_DUP;
                    end else if (s_q.idx == LAST_IDX) begin
                        s_d.st   = SQ_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.idx = s_q.idx + RIDX_W'(1);
                        s_d.st  = SQ_REQ;
                    end
                end
            end
            SQ_DUP: begin
                tbl_we    = 1'b1;
                tbl_waddr = SLOT_W'(s_q.idx) + SLOT_W'(NRATES);
                tbl_wdata = s_q.dur;
                if (s_q.idx == LAST_IDX) begin
                    s_d.st   = SQ_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.idx = s_q.idx + RIDX_W'(1);
                    s_d.st  = SQ_REQ;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy = (s_q.st != SQ_IDLE);
    assign done = s_q.done;

    // R8: done lasts a single cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the walk is over when done shows
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: the latched mode holds for the whole walk
    p_mode_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(s_q.hi));

    // R5: a first-slot write only happens with a calculator result in hand
    p_wr_after_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && s_q.st != SQ_DUP) |-> calc_out_valid);

    // R3: the index stays in range during a walk
    p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(s_q.idx) < NRATES));

endmodule

// File: tb/test_ack_dur_table_gen.sv
module test_ack_dur_table_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       ack_hi_en = 1'b0;
    logic       busy, done;
    logic [4:0] rd_addr = '0;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ack_dur_table_gen i_ack_dur_table_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ack_hi_en (ack_hi_en),
        .busy      (busy),
        .done      (done),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    function automatic int rate_of(int i);
        int r [12] = '{10, 20, 55, 110, 60, 90, 120, 180, 240, 360, 480, 540};
        return r[i];
    endfunction

    function automatic int ceil_div(int a, int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int dur_of(int ai);
        if (ai < 4) return 10 + 192 + ceil_div(800, rate_of(ai));
        return 16 + 20 + 4 * ceil_div(1020, 4 * rate_of(ai));
    endfunction

    function automatic int map_of(int i, bit hi);
        if (!hi) return (i < 4) ? 0 : 4;
        if (i == 0) return 0;
        if (i < 4)  return 1;
        if (i < 6)  return 4;
        if (i < 8)  return 6;
        return 8;
    endfunction

    function automatic int exp_slot(int s, bit hi);
        if (s < 12) return dur_of(map_of(s, hi));
        if (s >= 13 && s <= 15) return dur_of(map_of(s - 12, hi));
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic read_slot(int s, output int v);
        rd_addr = 5'(s);
        #1;
        v = int'(rd_data);
    endtask

    task automatic check_table(bit hi, string mtag);
        for (int s = 0; s < 32; s++) begin
            int v;
            string tag;
            read_slot(s, v);
            if (s >= 24)                tag = "R9";
            else if (s >= 12)           tag = "R7";
            else if (s < 4)             tag = {"R5/", mtag};
            else                        tag = {"R6/", mtag};
            check($sformatf("%s slot %0d", tag, s), v, exp_slot(s, hi));
        end
    endtask

    // walk and wait; optionally disturb mid-walk
    task automatic run_walk(bit hi, bit disturb);
        int cyc;
        bit seen;
        int dones;
        @(negedge clk);
        ack_hi_en = hi;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", int'(busy), 1);
        cyc = 0;
        seen = 0;
        while (!seen && cyc < 5000) begin
            if (disturb && cyc == 20) ack_hi_en = ~hi;   // R10
            if (disturb && cyc == 40) start = 1'b1;      // R2
            if (disturb && cyc == 41) start = 1'b0;
            @(negedge clk);
            cyc++;
            if (done) seen = 1;
        end
        check("R8 done seen", int'(seen), 1);
        check("R8 busy low with done", int'(busy), 0);
        @(negedge clk);
        check("R8 done single cycle", int'(done), 0);
        dones = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (done) dones++;
        end
        check("R2 no extra walk", dones, 0);
        check("R2 idle after walk", int'(busy), 0);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy at reset", int'(busy), 0);
        check("R1 done at reset", int'(done), 0);
        for (int s = 0; s < 32; s++) begin
            int v;
            read_slot(s, v);
            check($sformatf("R1 slot %0d at reset", s), v, 0);
        end

        run_walk(1'b0, 1'b1);
        check_table(1'b0, "R3 R10");

        run_walk(1'b1, 1'b0);
        check_table(1'b1, "R4 R11");

        run_walk(1'b0, 1'b0);
        check_table(1'b0, "R3 R11");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule